// File: doc/BRIEF.md
# Port-Bitmap Transmit Queue Scheduler

This block holds one descriptor queue per output port and keeps a one-bit-per-port occupancy vector. The bit for a port is set whenever a descriptor is added to that port's queue. It is cleared when a dequeue empties the queue. A single enqueue controller takes one descriptor at a time, together with its destination port. It claims that queue's lock, appends the descriptor, sets the occupancy bit and then gives the lock back. If the queue is full, the descriptor is refused and the port's overflow line pulses.

A scheduler walks the occupancy vector one port per cycle in circular order. When it reaches a port that holds data and no worker is already serving that port, it hands an assignment to the lowest-numbered idle worker. An assignment is a port index plus a strobe. Each worker then runs the same sequence:
1. Lock the assigned queue, waiting while the enqueue side holds it.
2. Pop the head descriptor.
3. Release the lock.
4. Present the descriptor on its own transmit-FIFO valid/ready handshake.

The worker raises its done pulse in the cycle the FIFO accepts the entry. A port stays bound to its worker until that done pulse, so descriptors of one port leave in the order they arrived.

Top module: `tx_port_sched`

## Requirements
- R1: After reset, `enq_ready_o` is 1, every `tx_valid_o` bit is 0 and `ports_with_pkts_o` is all zero.
- R2: Every accepted descriptor leaves exactly once, on a worker whose `tx_port_o` field equals the enqueue port. Descriptors of one port leave in enqueue order. Worker w's port is `tx_port_o[w*4 +: 4]` and its descriptor is `tx_desc_o[w*16 +: 16]`.
- R3: Each queue holds 8 descriptors. An enqueue to a full queue is not stored, and `enq_ovf_o[port]` is 1 for exactly one cycle.
- R4: Bit p of `ports_with_pkts_o` rises only after an append to queue p. It falls only after a dequeue that empties queue p.
- R5: No two busy workers are ever bound to the same port.
- R6: The scheduler visits ports in ascending circular order, one port per cycle, and resumes after the last port it served. With a single descriptor in each of several ports, the ports are served in a rotation of ascending order.
- R7: A queue lock has a single holder at a time. Appends and dequeues happen only under the lock. The lock is still held in the cycle after an append or a dequeue, so the occupancy bit is updated before the lock is released.
- R8: A worker's `tx_valid_o` bit and its descriptor stay stable until `tx_ready_i` for that worker is 1. `tx_done_o` pulses in that accepting cycle and the worker then becomes idle.
- R9: The three workers run in parallel. With three ports loaded and every ready low, all three `tx_valid_o` bits are 1 at once, on three distinct ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enq_valid_i | input | 1 | Enqueue request |
| enq_ready_o | output | 1 | Enqueue controller idle; a request is taken when both are 1 |
| enq_port_i | input | 4 | Destination port of the descriptor |
| enq_desc_i | input | 16 | Descriptor to append |
| enq_ovf_o | output | 16 | One-cycle pulse per port on a refused enqueue |
| ports_with_pkts_o | output | 16 | Occupancy vector, one bit per port |
| tx_valid_o | output | 3 | Transmit-FIFO valid, one bit per worker |
| tx_ready_i | input | 3 | Transmit-FIFO ready, one bit per worker |
| tx_port_o | output | 12 | Port index per worker, 4 bits each |
| tx_desc_o | output | 48 | Descriptor per worker, 16 bits each |
| tx_done_o | output | 3 | Done pulse per worker |

## Verification
The assertions take for granted that `enq_port_i` and `enq_desc_i` are stable while `enq_valid_i` is high. They also assume a worker's ready line can stay low indefinitely without the rest of the block stalling. The stimulus only changes the enqueue inputs at falling edges, in cycles when the controller shows ready. Ready lines are held low on purpose to freeze workers in the valid state, which builds full queues and a known set of bound ports before they are released.

// File: rtl/tx_sched_pkg.sv
package tx_sched_pkg;
  typedef enum logic [1:0] {E_IDLE, E_LOCK, E_WRITE, E_UNLOCK} enq_st_e;
  typedef enum logic [2:0] {W_IDLE, W_LOCK, W_DEQ, W_UNLOCK, W_MOVE} wrk_st_e;
endpackage

// File: rtl/tx_port_queue.sv
module tx_port_queue #(
  parameter int DEPTH = 8,
  parameter int DW    = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enq_lock_req_i,
  input  logic          enq_unlock_i,
  input  logic          push_req_i,
  input  logic [DW-1:0] desc_i,
  input  logic          wrk_lock_req_i,
  input  logic          wrk_unlock_i,
  input  logic          pop_req_i,
  output logic          enq_gnt_o,
  output logic          wrk_gnt_o,
  output logic [DW-1:0] head_o,
  output logic          push_o,
  output logic          pop_o,
  output logic          ovf_o,
  output logic          occ_o,
  output logic          lock_held_o,
  output logic          lock_enq_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          held_q, by_enq_q, occ_q, full;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] a);
    return (a == AW'(DEPTH - 1)) ? '0 : a + 1'b1;
  endfunction

  assign full      = (cnt_q == CW'(DEPTH));
  // enqueue side wins a simultaneous request
  assign enq_gnt_o = enq_lock_req_i && !held_q;
  assign wrk_gnt_o = wrk_lock_req_i && !held_q && !enq_lock_req_i;
  assign push_o    = push_req_i && held_q && by_enq_q && !full;
  assign pop_o     = pop_req_i && held_q && !by_enq_q && (cnt_q != '0);
  assign ovf_o     = push_req_i && full;
  assign head_o    = mem[rd_q];
  assign occ_o     = occ_q;
  assign lock_held_o = held_q;
  assign lock_enq_o  = by_enq_q;

  always_ff @(posedge clk_i) begin
    if (push_o) mem[wr_q] <= desc_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0; rd_q <= '0; cnt_q <= '0;
      held_q <= 1'b0; by_enq_q <= 1'b0; occ_q <= 1'b0;
    end else begin
      if (enq_gnt_o) begin
        held_q <= 1'b1; by_enq_q <= 1'b1;
      end else if (wrk_gnt_o) begin
        held_q <= 1'b1; by_enq_q <= 1'b0;
      end else if (held_q && ((by_enq_q && enq_unlock_i) || (!by_enq_q && wrk_unlock_i))) begin
        held_q <= 1'b0;
      end
      if (push_o) begin
        wr_q  <= inc(wr_q);
        cnt_q <= cnt_q + 1'b1;
        occ_q <= 1'b1;
      end else if (pop_o) begin
        rd_q  <= inc(rd_q);
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) occ_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tx_worker.sv
module tx_worker
  import tx_sched_pkg::*;
#(
  parameter int PW = 4,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          assign_i,
  input  logic [PW-1:0] assign_port_i,
  input  logic          gnt_i,
  input  logic [DW-1:0] head_i,
  input  logic          tx_ready_i,
  output logic          lock_req_o,
  output logic          pop_o,
  output logic          unlock_o,
  output logic          busy_o,
  output logic [PW-1:0] port_o,
  output logic          tx_valid_o,
  output logic [DW-1:0] tx_desc_o,
  output logic          done_o
);
  wrk_st_e       st_q;
  logic [PW-1:0] port_q;
  logic [DW-1:0] desc_q;

  assign lock_req_o = (st_q == W_LOCK);
  assign pop_o      = (st_q == W_DEQ);
  assign unlock_o   = (st_q == W_UNLOCK);
  assign tx_valid_o = (st_q == W_MOVE);
  assign busy_o     = (st_q != W_IDLE);
  assign done_o     = tx_valid_o && tx_ready_i;
  assign port_o     = port_q;
  assign tx_desc_o  = desc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= W_IDLE; port_q <= '0; desc_q <= '0;
    end else begin
      unique case (st_q)
        W_IDLE:   if (assign_i) begin port_q <= assign_port_i; st_q <= W_LOCK; end
        W_LOCK:   if (gnt_i) st_q <= W_DEQ;
        W_DEQ:    begin desc_q <= head_i; st_q <= W_UNLOCK; end
        W_UNLOCK: st_q <= W_MOVE;
        W_MOVE:   if (tx_ready_i) st_q <= W_IDLE;
        default:  st_q <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tx_rr_sched.sv
module tx_rr_sched #(
  parameter int NP = 16,
  parameter int NW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NP-1:0] occ_i,
  input  logic [NP-1:0] port_busy_i,
  input  logic [NW-1:0] wrk_busy_i,
  output logic [NW-1:0] assign_o,
  output logic [((NP > 1) ? $clog2(NP) : 1)-1:0] assign_port_o
);
  localparam int PW = (NP > 1) ? $clog2(NP) : 1;
  localparam int WW = (NW > 1) ? $clog2(NW) : 1;

  logic [PW-1:0] ptr_q;
  logic [WW-1:0] pick;
  logic          elig, found;

  assign elig          = occ_i[ptr_q] && !port_busy_i[ptr_q];
  assign assign_port_o = ptr_q;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int w = NW - 1; w >= 0; w--) begin
      if (!wrk_busy_i[w]) begin
        pick  = WW'(w);
        found = 1'b1;
      end
    end
    assign_o = '0;
    if (elig && found) assign_o[pick] = 1'b1;
  end

  // hold on a serviceable port until a worker frees up
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (!elig || found) ptr_q <= (ptr_q == PW'(NP - 1)) ? '0 : ptr_q + 1'b1;
  end
endmodule

// File: rtl/tx_port_sched.sv
module tx_port_sched
  import tx_sched_pkg::*;
#(
  parameter int NUM_PORTS   = 16,
  parameter int QUEUE_DEPTH = 8,
  parameter int NUM_WORKERS = 3,
  parameter int DESC_W      = 16,
  localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          enq_valid_i,
  output logic                          enq_ready_o,
  input  logic [PW-1:0]                 enq_port_i,
  input  logic [DESC_W-1:0]             enq_desc_i,
  output logic [NUM_PORTS-1:0]          enq_ovf_o,
  output logic [NUM_PORTS-1:0]          ports_with_pkts_o,
  output logic [NUM_WORKERS-1:0]        tx_valid_o,
  input  logic [NUM_WORKERS-1:0]        tx_ready_i,
  output logic [NUM_WORKERS*PW-1:0]     tx_port_o,
  output logic [NUM_WORKERS*DESC_W-1:0] tx_desc_o,
  output logic [NUM_WORKERS-1:0]        tx_done_o
);
  localparam int NP = NUM_PORTS;
  localparam int NW = NUM_WORKERS;
  localparam int DW = DESC_W;

  enq_st_e       enq_st_q;
  logic [PW-1:0] enq_port_q;
  logic [DW-1:0] enq_desc_q;

  logic [NP-1:0] q_enq_lock_req, q_enq_unlock, q_push_req, q_enq_gnt;
  logic [NP-1:0] q_wrk_req, q_wrk_unlock, q_pop_req, q_wrk_gnt;
  logic [NP-1:0] q_push, q_pop, q_lock_held, q_lock_enq, port_busy;
  logic [DW-1:0] q_head [NP];

  logic [NW-1:0] w_assign, w_busy, w_gnt, w_lock_req, w_pop, w_unlock;
  logic [PW-1:0] w_port [NW];
  logic [DW-1:0] w_head [NW];
  logic [PW-1:0] sched_port;
  logic [NW*PW-1:0] w_port_flat;

  assign enq_ready_o = (enq_st_q == E_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enq_st_q <= E_IDLE; enq_port_q <= '0; enq_desc_q <= '0;
    end else begin
      unique case (enq_st_q)
        E_IDLE: if (enq_valid_i) begin
          enq_port_q <= enq_port_i;
          enq_desc_q <= enq_desc_i;
          enq_st_q   <= E_LOCK;
        end
        E_LOCK:   if (q_enq_gnt[enq_port_q]) enq_st_q <= E_WRITE;
        E_WRITE:  enq_st_q <= E_UNLOCK;
        E_UNLOCK: enq_st_q <= E_IDLE;
        default:  enq_st_q <= E_IDLE;
      endcase
    end
  end

  always_comb begin
    q_enq_lock_req = '0;
    q_push_req     = '0;
    q_enq_unlock   = '0;
    q_enq_lock_req[enq_port_q] = (enq_st_q == E_LOCK);
    q_push_req[enq_port_q]     = (enq_st_q == E_WRITE);
    q_enq_unlock[enq_port_q]   = (enq_st_q == E_UNLOCK);
  end

  // route worker requests to queues; a port is bound to at most one worker
  always_comb begin
    q_wrk_req    = '0;
    q_pop_req    = '0;
    q_wrk_unlock = '0;
    port_busy    = '0;
    for (int w = 0; w < NW; w++) begin
      q_wrk_req[w_port[w]]    = q_wrk_req[w_port[w]]    | w_lock_req[w];
      q_pop_req[w_port[w]]    = q_pop_req[w_port[w]]    | w_pop[w];
      q_wrk_unlock[w_port[w]] = q_wrk_unlock[w_port[w]] | w_unlock[w];
      port_busy[w_port[w]]    = port_busy[w_port[w]]    | w_busy[w];
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_q
    tx_port_queue #(.DEPTH(QUEUE_DEPTH), .DW(DW)) u_q (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .enq_lock_req_i (q_enq_lock_req[p]),
      .enq_unlock_i   (q_enq_unlock[p]),
      .push_req_i     (q_push_req[p]),
      .desc_i         (enq_desc_q),
      .wrk_lock_req_i (q_wrk_req[p]),
      .wrk_unlock_i   (q_wrk_unlock[p]),
      .pop_req_i      (q_pop_req[p]),
      .enq_gnt_o      (q_enq_gnt[p]),
      .wrk_gnt_o      (q_wrk_gnt[p]),
      .head_o         (q_head[p]),
      .push_o         (q_push[p]),
      .pop_o          (q_pop[p]),
      .ovf_o          (enq_ovf_o[p]),
      .occ_o          (ports_with_pkts_o[p]),
      .lock_held_o    (q_lock_held[p]),
      .lock_enq_o     (q_lock_enq[p])
    );
  end

  tx_rr_sched #(.NP(NP), .NW(NW)) u_sched (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .occ_i         (ports_with_pkts_o),
    .port_busy_i   (port_busy),
    .wrk_busy_i    (w_busy),
    .assign_o      (w_assign),
    .assign_port_o (sched_port)
  );

  for (genvar w = 0; w < NW; w++) begin : g_w
    assign w_gnt[w]  = q_wrk_gnt[w_port[w]];
    assign w_head[w] = q_head[w_port[w]];
    assign tx_port_o[w*PW +: PW] = w_port[w];
    assign w_port_flat[w*PW +: PW] = w_port[w];

    tx_worker #(.PW(PW), .DW(DW)) u_w (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .assign_i      (w_assign[w]),
      .assign_port_i (sched_port),
      .gnt_i         (w_gnt[w]),
      .head_i        (w_head[w]),
      .tx_ready_i    (tx_ready_i[w]),
      .lock_req_o    (w_lock_req[w]),
      .pop_o         (w_pop[w]),
      .unlock_o      (w_unlock[w]),
      .busy_o        (w_busy[w]),
      .port_o        (w_port[w]),
      .tx_valid_o    (tx_valid_o[w]),
      .tx_desc_o     (tx_desc_o[w*DW +: DW]),
      .done_o        (tx_done_o[w])
    );
  end
endmodule

// File: rtl/tx_port_sched_chk.sv
module tx_port_sched_chk #(
  parameter int NP = 16,
  parameter int NW = 3,
  parameter int DW = 16,
  parameter int PW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [NP-1:0] enq_ovf_o,
  input logic [NP-1:0] ports_with_pkts_o,
  input logic [NP-1:0] q_push,
  input logic [NP-1:0] q_pop,
  input logic [NP-1:0] q_lock_held,
  input logic [NW-1:0] w_busy,
  input logic [NW*PW-1:0] w_port_flat,
  input logic [NW-1:0] tx_valid_o,
  input logic [NW-1:0] tx_ready_i,
  input logic [NW*DW-1:0] tx_desc_o
);
  assert_ovf_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(enq_ovf_o));
  assert_push_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(q_push));

  for (genvar p = 0; p < NP; p++) begin : g_p
    assert_no_store_on_ovf_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      enq_ovf_o[p] |-> !q_push[p]);
    assert_occ_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ports_with_pkts_o[p]) |-> $past(q_push[p]));
    assert_occ_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(ports_with_pkts_o[p]) |-> $past(q_pop[p]));
    assert_occ_fall_locked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(ports_with_pkts_o[p]) |-> q_lock_held[p]);
    assert_push_locked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      q_push[p] |=> q_lock_held[p]);
    assert_pop_locked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      q_pop[p] |=> q_lock_held[p]);
    assert_no_push_pop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(q_push[p] && q_pop[p]));
  end

  for (genvar a = 0; a < NW; a++) begin : g_a
    assert_hold_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tx_valid_o[a] && !tx_ready_i[a] |=> tx_valid_o[a] && $stable(tx_desc_o[a*DW +: DW]));
    for (genvar b = a + 1; b < NW; b++) begin : g_b
      assert_distinct_port_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        w_busy[a] && w_busy[b] |-> w_port_flat[a*PW +: PW] != w_port_flat[b*PW +: PW]);
    end
  end
endmodule

bind tx_port_sched tx_port_sched_chk #(
  .NP(NUM_PORTS), .NW(NUM_WORKERS), .DW(DESC_W), .PW(PW)
) u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .enq_ovf_o         (enq_ovf_o),
  .ports_with_pkts_o (ports_with_pkts_o),
  .q_push            (q_push),
  .q_pop             (q_pop),
  .q_lock_held       (q_lock_held),
  .w_busy            (w_busy),
  .w_port_flat       (w_port_flat),
  .tx_valid_o        (tx_valid_o),
  .tx_ready_i        (tx_ready_i),
  .tx_desc_o         (tx_desc_o)
);

// File: tb/tb_tx_port_sched.sv
module tb_tx_port_sched;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 16, NW = 3, DW = 16, PW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enq_valid = 1'b0;
  logic [PW-1:0] enq_port = '0;
  logic [DW-1:0] enq_desc = '0;
  logic [NW-1:0] tx_ready = '0;
  logic enq_ready;
  logic [NP-1:0] enq_ovf, occ;
  logic [NW-1:0] tx_valid, tx_done;
  logic [NW*PW-1:0] tx_port;
  logic [NW*DW-1:0] tx_desc;

  int checks = 0, fails = 0;
  int done_cnt = 0, ovf_cnt = 0, ovf_port = -1;
  int d_port [512];
  int d_desc [512];

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_port_sched dut (
    .clk_i(clk), .rst_ni(rst_n),
    .enq_valid_i(enq_valid), .enq_ready_o(enq_ready),
    .enq_port_i(enq_port), .enq_desc_i(enq_desc),
    .enq_ovf_o(enq_ovf), .ports_with_pkts_o(occ),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
    .tx_port_o(tx_port), .tx_desc_o(tx_desc), .tx_done_o(tx_done)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      for (int w = 0; w < NW; w++) begin
        if (tx_done[w] && done_cnt < 512) begin
          d_port[done_cnt] = int'(tx_port[w*PW +: PW]);
          d_desc[done_cnt] = int'(tx_desc[w*DW +: DW]);
          done_cnt++;
        end
      end
      for (int p = 0; p < NP; p++) if (enq_ovf[p]) begin ovf_cnt++; ovf_port = p; end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enq(input int p, input int d);
    while (!enq_ready) @(negedge clk);
    enq_valid = 1'b1;
    enq_port  = PW'(p);
    enq_desc  = DW'(d);
    @(negedge clk);
    enq_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int base, ov0, start, seen, ok;
    int cnt [4];
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1
    check(enq_ready == 1'b1, "R1 enq_ready", int'(enq_ready), 1);
    check(tx_valid == '0, "R1 tx_valid", int'(tx_valid), 0);
    check(occ == '0, "R1 occupancy", int'(occ), 0);

    // per-port sweep: R2 R3 R4 R8
    for (int p = 0; p < NP; p++) begin
      tx_ready = '0;
      base = done_cnt;
      ov0  = ovf_cnt;
      enq(p, p * 256);
      cyc(40);
      check(occ[p] == 1'b0, "R4 cleared after last dequeue", int'(occ[p]), 0);
      check(tx_valid == 3'b001, "R8 valid held", int'(tx_valid), 1);
      check(int'(tx_port[PW-1:0]) == p, "R2 port field", int'(tx_port[PW-1:0]), p);
      check(int'(tx_desc[DW-1:0]) == p * 256, "R2 desc field", int'(tx_desc[DW-1:0]), p * 256);
      for (int k = 1; k <= 8; k++) enq(p, p * 256 + k);
      cyc(8);
      check(ovf_cnt == ov0, "R3 no overflow up to depth", ovf_cnt - ov0, 0);
      check(occ[p] == 1'b1, "R4 set on append", int'(occ[p]), 1);
      check(occ == (16'(1) << p), "R4 only target bit", int'(occ), 1 << p);
      enq(p, p * 256 + 9);
      cyc(8);
      check(ovf_cnt == ov0 + 1, "R3 overflow pulse", ovf_cnt - ov0, 1);
      check(ovf_port == p, "R3 overflow port", ovf_port, p);
      tx_ready = '1;
      cyc(200);
      check(done_cnt - base == 9, "R2 delivered count", done_cnt - base, 9);
      for (int i = 0; i < 9; i++) begin
        check(d_port[base + i] == p, "R2 port order", d_port[base + i], p);
        check(d_desc[base + i] == p * 256 + i, "R2 desc order", d_desc[base + i], p * 256 + i);
      end
      check(occ == '0, "R4 empty after drain", int'(occ), 0);
    end

    // parallel workers and round-robin: R9 R6
    tx_ready = '0;
    base = done_cnt;
    for (int p = 13; p < 16; p++) enq(p, 16'hA000 + p);
    cyc(60);
    check(tx_valid == 3'b111, "R9 three valid", int'(tx_valid), 7);
    seen = 0;
    for (int w = 0; w < NW; w++) seen |= 1 << int'(tx_port[w*PW +: PW]);
    check(seen == 32'hE000, "R9 distinct ports", seen, 32'hE000);
    for (int p = 0; p < 13; p++) enq(p, 16'hB000 + p);
    cyc(40);
    check(occ == 16'h1FFF, "R4 loaded ports", int'(occ), 16'h1FFF);
    tx_ready = '1;
    cyc(300);
    check(done_cnt - base == 16, "R6 served count", done_cnt - base, 16);
    seen = 0;
    for (int i = 0; i < 3; i++) seen |= 1 << d_port[base + i];
    check(seen == 32'hE000, "R9 first served", seen, 32'hE000);
    start = base + 3;
    for (int i = 0; i < 12; i++) begin
      check(d_port[start + i + 1] == (d_port[start + i] + 1) % 13, "R6 rotation order",
            d_port[start + i + 1], (d_port[start + i] + 1) % 13);
    end

    // interleaved stress with live workers: R2 R7
    base = done_cnt;
    for (int i = 0; i < 40; i++) enq(i % 4, (i % 4) * 256 + i / 4);
    cyc(300);
    check(done_cnt - base == 40, "R7 stress count", done_cnt - base, 40);
    for (int q = 0; q < 4; q++) cnt[q] = 0;
    ok = 1;
    for (int i = base; i < done_cnt; i++) begin
      if (d_port[i] < 4) begin
        if (d_desc[i] != d_port[i] * 256 + cnt[d_port[i]]) ok = 0;
        cnt[d_port[i]]++;
      end else ok = 0;
    end
    check(ok == 1, "R2 per-port order under load", ok, 1);
    check(cnt[0] == 10 && cnt[3] == 10, "R7 per-port count", cnt[0] + cnt[3], 20);
    check(occ == '0 && tx_valid == '0, "R8 idle after drain", int'(occ), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule